// File: doc/BRIEF.md
# Programmable pulse-swallow frequency divider

This block divides a fast input clock by any integer from 256 to 271. A small prescaler built from three flops divides the input by 4 or by 5, depending on a modulus-control line. Its output drives a chain of six toggle stages, which divides it by a further 64. The last toggle stage is the divided clock. A decoder watches the toggle-stage taps and raises the modulus control for exactly `ratio_sel` prescaler periods in each output period. Each of those periods swallows one extra input cycle, so one output period lasts 256 + `ratio_sel` input cycles.

The swallow windows are binary weighted. Bit i of the ratio word enables a window of 2^i prescaler periods. The windows are decoded from the low four taps and never overlap. They are qualified by the upper two taps, so they fall inside one quarter of the 64-period cycle. The modulus control is a flop that reloads only at the end of a prescaler period. Tap skew therefore cannot put a spike into the prescaler. The ratio word is captured when the divided clock rises, so a new value applies from the following output period on.

Top module: `pswallow_div`

## Requirements
- R1: Between consecutive rising edges of `div_out` there are exactly 256 + `ratio_sel` input clock cycles, for every `ratio_sel` from 0 to 15.
- R2: With modulus control low, the prescaler repeats every 4 input cycles, and `f4_out` is high for 2 of them.
- R3: With modulus control high, the prescaler repeats every 5 input cycles, and `f4_out` is high for 3 of them. Over one output period `f4_out` is high for 128 + `ratio_sel` cycles.
- R4: `mod_ctl_out` changes only at the end of a prescaler period. Over one output period it is high for exactly 5 × `ratio_sel` input cycles.
- R5: When the captured ratio is 0, `mod_ctl_out` never goes high and the block divides by plain 256.
- R6: `div_out` is high for exactly 128 input cycles of every output period. All swallowed cycles fall in its low half.
- R7: The ratio word is captured only at a rising edge of `div_out`. A change made at any point inside an output period, including the cycle just before its closing rising edge, leaves that period's length unchanged.
- R8: While `rst_n` is low at a clock edge, all taps, `div_out`, `f4_out` and `mod_ctl_out` are 0 and the captured ratio is 0. After release, the first rising edge of `div_out` follows after exactly 128 input cycles.
- R9: `tap_out` bit k is toggle stage k, with bit 5 equal to `div_out`. The taps change only at prescaler-period ends, and at each rising edge of `div_out` they read binary 100000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| ratio_sel | input | 4 | Ratio word; division is 256 + ratio_sel |
| div_out | output | 1 | Divided clock (last toggle stage) |
| f4_out | output | 1 | Prescaler output, divide by 4 or 5 |
| tap_out | output | 6 | Toggle-stage taps, bit 0 first stage, bit 5 last |
| mod_ctl_out | output | 1 | Registered modulus control fed to the prescaler |

## Verification
The ratio word is swept through all sixteen values in turn. In each period the next value is written at a random cycle, so one sweep covers both the length of every ratio and the rule that a change waits for the next boundary. Seeded random ratio sequences follow, together with directed changes on the first cycle of a period and on the last cycle before its closing edge. Within each period the bench counts the high cycles of the output, the prescaler and the modulus control separately. This tells a wrong swallow count apart from swallows that land in the wrong half or last the wrong length. A reset in the middle of a run checks the cleared state and the exact delay to the first edge afterwards.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

    // Three-flop prescaler state: s2 is the prescaler output.
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } pre_state_t;

    // Phase right after a period boundary.
    localparam pre_state_t PRE_START = '{s1: 1'b0, s2: 1'b0, s3: 1'b1};

endpackage

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler
    import pswallow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode5,
    output logic f4,
    output logic tick
);
    pre_state_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = ~(st_q.s2 & st_q.s3);
        st_d.s2 = st_q.s1;
        // Third flop forced high in divide-by-4, follows s2 in divide-by-5.
        st_d.s3 = st_q.s2 | ~mode5;
        if (!rst_n) st_d = PRE_START;
    end

    always_ff @(posedge clk) st_q <= st_d;

    // Last phase of a period: next edge always lands on PRE_START.
    assign tick = ~st_q.s1 & st_q.s2 & st_q.s3;
    assign f4   = st_q.s2;

    assert_tick_f4_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!f4 && !tick));

    // R3: a period that started in divide-by-5 dips s3 low before the boundary.
    assert_mode5_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.s2 && !st_q.s3) |-> $past(mode5));

endmodule

// File: rtl/pswallow_ripple.sv
module pswallow_ripple #(
    parameter int STAGES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [STAGES-1:0] taps,
    output logic [STAGES-1:0] taps_next
);
    logic [STAGES-1:0] tgl_q, tgl_d;
    logic [STAGES:0]   carry;

    assign carry[0] = tick;

    // Each stage toggles when the stage before it falls.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        assign carry[k+1] = carry[k] & tgl_q[k];
        assign tgl_d[k]   = rst_n ? (tgl_q[k] ^ carry[k]) : 1'b0;
    end

    always_ff @(posedge clk) tgl_q <= tgl_d;

    assign taps      = tgl_q;
    assign taps_next = tgl_d;

    assert_taps_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(taps));

endmodule

// File: rtl/pswallow_modctl.sv
module pswallow_modctl #(
    parameter int RATIO_W = 4,
    parameter int STAGES  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [STAGES-1:0]  cnt_next,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic               mode5
);
    localparam logic [STAGES-1:0] HALF_V = STAGES'(1) << (STAGES - 1);
    localparam int                HI_W   = STAGES - RATIO_W;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               mc;
    } ctl_t;

    ctl_t s_q, s_d;

    // Window i covers 2^i slots: all bits above i set, bit i clear.
    function automatic logic slot_hit(input logic [RATIO_W-1:0] low,
                                      input logic [RATIO_W-1:0] r);
        logic hit;
        logic ones;
        hit = 1'b0;
        for (int i = 0; i < RATIO_W; i++) begin
            ones = 1'b1;
            for (int j = i + 1; j < RATIO_W; j++) ones = ones & low[j];
            if (ones && !low[i] && r[i]) hit = 1'b1;
        end
        return hit;
    endfunction

    logic quarter;
    assign quarter = (cnt_next[STAGES-1:RATIO_W] == HI_W'(0));

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.mc = quarter & slot_hit(cnt_next[RATIO_W-1:0], s_q.ratio);
            if (cnt_next == HALF_V) s_d.ratio = ratio_in;
        end
        if (!rst_n) s_d = '0;
    end

    always_ff @(posedge clk) s_q <= s_d;

    assign mode5 = s_q.mc;

    assert_mc_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(mode5));

    assert_mc_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.ratio == '0) |=> !mode5);

    assert_ratio_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(s_q.ratio));

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
    parameter int RATIO_W = 4,
    parameter int STAGES  = 6
) (
    input  logic               clk_in,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_sel,
    output logic               div_out,
    output logic               f4_out,
    output logic [STAGES-1:0]  tap_out,
    output logic               mod_ctl_out
);
    logic              tick;
    logic              mode5;
    logic [STAGES-1:0] taps;
    logic [STAGES-1:0] taps_next;

    pswallow_prescaler u_pre (
        .clk   (clk_in),
        .rst_n (rst_n),
        .mode5 (mode5),
        .f4    (f4_out),
        .tick  (tick)
    );

    pswallow_ripple #(.STAGES(STAGES)) u_chain (
        .clk       (clk_in),
        .rst_n     (rst_n),
        .tick      (tick),
        .taps      (taps),
        .taps_next (taps_next)
    );

    pswallow_modctl #(.RATIO_W(RATIO_W), .STAGES(STAGES)) u_ctl (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .tick     (tick),
        .cnt_next (taps_next),
        .ratio_in (ratio_sel),
        .mode5    (mode5)
    );

    assign tap_out     = taps;
    assign div_out     = taps[STAGES-1];
    assign mod_ctl_out = mode5;

    // R1: divided clock only rises on a prescaler-period boundary.
    assert_out_on_tick_R1: assert property (@(posedge clk_in) disable iff (!rst_n)
        $rose(div_out) |-> $past(tick));

endmodule

// File: tb/pswallow_div_test.sv
module pswallow_div_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] ratio;
    logic       div_out;
    logic       f4_out;
    logic [5:0] tap_out;
    logic       mod_ctl_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    pswallow_div uut (
        .clk_in      (clk),
        .rst_n       (rst_n),
        .ratio_sel   (ratio),
        .div_out     (div_out),
        .f4_out      (f4_out),
        .tap_out     (tap_out),
        .mod_ctl_out (mod_ctl_out)
    );

    function automatic int exp_period(input int r);
        return 256 + r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Wait at negedges until div_out is seen rising.
    task automatic sync_rise();
        logic p;
        do begin
            p = div_out;
            @(negedge clk);
        end while (!(!p && div_out));
    endtask

    // Entered right after a rising edge; returns right after the next one.
    task automatic measure(input int chg_at, input logic [3:0] chg_val,
                           output int len, output int hi, output int f4c,
                           output int mcc, output logic [5:0] tap_rise);
        logic p;
        len = 0;
        hi  = div_out ? 1 : 0;
        f4c = f4_out ? 1 : 0;
        mcc = mod_ctl_out ? 1 : 0;
        p   = div_out;
        forever begin
            @(negedge clk);
            len++;
            if (!p && div_out) break;
            if (len == chg_at) ratio = chg_val;
            hi  += div_out ? 1 : 0;
            f4c += f4_out ? 1 : 0;
            mcc += mod_ctl_out ? 1 : 0;
            p = div_out;
        end
        tap_rise = tap_out;
    endtask

    // Check one period whose captured ratio is cur.
    task automatic run_period(input int cur, input int chg_at, input logic [3:0] nxt);
        int len, hi, f4c, mcc;
        logic [5:0] tr;
        measure(chg_at, nxt, len, hi, f4c, mcc, tr);
        check(len == exp_period(cur), (chg_at > 0) ? "R1/R7 period" : "R1 period", len, exp_period(cur));
        check(hi == 128, "R6 high time", hi, 128);
        if (cur == 0) begin
            check(f4c == 128, "R2 f4 high count", f4c, 128);
            check(mcc == 0, "R5 mod ctl idle", mcc, 0);
        end else begin
            check(f4c == 128 + cur, "R3 f4 high count", f4c, 128 + cur);
            check(mcc == 5 * cur, "R4 mod ctl cycles", mcc, 5 * cur);
        end
        check(tr == 6'b100000, "R9 taps at rise", int'(tr), 32);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int cur;
        int seed_dummy;
        seed_dummy = int'($urandom(32'd20517));
        rst_n = 1'b0;
        ratio = 4'd0;
        repeat (3) @(negedge clk);
        // R8: cleared state during reset
        check(tap_out == 6'd0, "R8 taps in reset", int'(tap_out), 0);
        check(div_out == 1'b0 && f4_out == 1'b0, "R8 outputs in reset", int'({div_out, f4_out}), 0);
        check(mod_ctl_out == 1'b0, "R8 mod ctl in reset", int'(mod_ctl_out), 0);
        rst_n = 1'b1;
        begin
            int n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!div_out);
            check(n == 128, "R8 first edge delay", n, 128);
        end

        // Sweep all sixteen ratios, each next value written mid-period (R1, R7).
        ratio = 4'd0;
        sync_rise();
        cur = 0;
        for (int a = 0; a < 16; a++) begin
            int at = 1 + int'($urandom_range(0, 250));
            run_period(cur, at, 4'(a));
            cur = a;
        end
        run_period(cur, 1, 4'd0);
        cur = 0;

        // Seeded random ratio sequence.
        for (int k = 0; k < 14; k++) begin
            logic [3:0] nv = 4'($urandom_range(0, 15));
            int at = 1 + int'($urandom_range(0, 254));
            run_period(cur, at, nv);
            cur = int'(nv);
        end

        // R7 corner: change on the last cycle before the closing edge.
        run_period(cur, exp_period(cur) - 1, 4'd15);
        cur = 15;
        run_period(cur, exp_period(cur) - 1, 4'd7);
        cur = 7;
        // R7 corner: change on the first cycle, then hold.
        run_period(cur, 1, 4'd0);
        cur = 0;
        run_period(cur, 1, 4'd9);
        cur = 9;
        run_period(cur, 0, 4'd9);

        // Mid-run synchronous reset (R8).
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(tap_out == 6'd0 && div_out == 1'b0, "R8 taps after mid reset", int'(tap_out), 0);
        check(mod_ctl_out == 1'b0 && f4_out == 1'b0, "R8 ctl after mid reset", int'({mod_ctl_out, f4_out}), 0);
        rst_n = 1'b1;
        ratio = 4'd5;
        sync_rise();
        run_period(5, 0, 4'd5);

        finish_run();
    end
endmodule